// File: doc/BRIEF.md
# Software-Refilled Shared Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for a processor core. Instruction fetches and data accesses both use it, and they share one fully associative table of page mappings. Pages are 4 KB. The upper 20 address bits form the page number. Every valid slot compares that number against the request in parallel. On a match, the physical address is the stored 20-bit physical page number followed by the unchanged 12-bit offset. All of this is produced in the same cycle as the request.

The block never walks a page table. When a lookup finds no match, it latches the missing page number into a register and raises a trap line for system software. Software then loads a mapping through a write port that names a slot, a virtual page, a physical page and a valid flag. Software can also drop a pending trap with an acknowledge input, or invalidate every slot at once.

Instruction and data requests pass through one lookup path. A data request takes that path ahead of an instruction request. When both arrive together, the instruction side is told to stall.

Top module: `sw_tlb`

## Requirements
- R1: A request address splits into a page number (bits 31:12) and an offset (bits 11:0). On a hit, `lk_paddr` is {stored physical page, offset}, and bits 11:0 equal the request's bits 11:0.
- R2: The table has 16 slots. A mapping written into any slot 0..15 can be found by its virtual page number, whatever the slot.
- R3: A slot whose valid flag is 0 never produces a hit, even when its stored page number matches the request.
- R4: On a lookup miss with no trap pending, the requested page number is stored in `miss_vpn` at the next clock edge, and `trap_req` goes to 1 at that edge.
- R5: While `trap_req` is 1, further misses leave `miss_vpn` and `trap_req` unchanged.
- R6: A pending trap clears at the next clock edge if `trap_ack` is 1 or `wr_en` is 1 in that cycle.
- R7: When both `dreq_valid` and `ireq_valid` are 1, the data address is translated, `lk_is_data` is 1 and `istall` is 1. With only an instruction request, `istall` is 0 and `lk_is_data` is 0.
- R8: A write with `wr_en` = 1 updates slot `wr_idx` at the clock edge. The new mapping is used by lookups from the next cycle on.
- R9: Reset and a one-cycle `flush_all` pulse both clear every valid flag, so lookups after either one miss. When `flush_all` and `wr_en` are 1 in the same cycle, the flush takes precedence.
- R10: If two valid slots hold the same virtual page number, the lower-numbered slot supplies the physical page.
- R11: The lookup is combinational. Whenever a request is present, exactly one of `lk_hit` and `lk_miss` is 1 in that same cycle. With no request, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ireq_valid | input | 1 | Instruction lookup request |
| ireq_vaddr | input | 32 | Instruction virtual address |
| dreq_valid | input | 1 | Data lookup request |
| dreq_vaddr | input | 32 | Data virtual address |
| istall | output | 1 | Instruction request lost arbitration this cycle |
| lk_hit | output | 1 | Served request matched a valid slot |
| lk_miss | output | 1 | Served request matched no valid slot |
| lk_is_data | output | 1 | Served request is the data request |
| lk_paddr | output | 32 | Translated physical address |
| trap_req | output | 1 | Miss trap pending for software |
| miss_vpn | output | 20 | Page number captured on the trapping miss |
| wr_en | input | 1 | Slot write strobe; also clears a pending trap |
| wr_idx | input | 4 | Slot to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_valid | input | 1 | Valid flag to store |
| trap_ack | input | 1 | Drops a pending trap |
| flush_all | input | 1 | Clears all valid flags |

## Verification
The lookup outputs `lk_hit`, `lk_miss`, `lk_paddr`, `lk_is_data` and `istall` are due in the same cycle as the request. The bench therefore drives requests on the falling edge and samples these outputs 1 ns later, before the next rising edge. The trap line, the captured page number and the effect of slot writes or flushes are each due one rising edge after their cause. Those are sampled on the falling edge that follows that rising edge. Each scenario deasserts its request after one cycle, so the expected trap state is known at every sample.

// File: rtl/tlb_pkg.sv
// Package: shared constants and the arbitration source type for the
// software-refilled translation buffer. Assumes 4 KB pages.
package tlb_pkg;
    parameter int TLB_VA_W    = 32;
    parameter int TLB_OFF_W   = 12;
    parameter int TLB_PPN_W   = 20;
    parameter int TLB_ENTRIES = 16;

    typedef enum logic {
        SRC_INST = 1'b0,
        SRC_DATA = 1'b1
    } tlb_src_e;
endpackage

// File: rtl/tlb_arbiter.sv
// Module: tlb_arbiter
// Picks one request for the shared lookup path. Data has fixed priority
// over instruction; the instruction side gets a stall when it loses.
// Assumes requests are single-cycle qualified by their valid lines.
module tlb_arbiter
    import tlb_pkg::*;
#(
    parameter int VA_W = TLB_VA_W
) (
    input  logic            i_valid,
    input  logic [VA_W-1:0] i_vaddr,
    input  logic            d_valid,
    input  logic [VA_W-1:0] d_vaddr,
    output logic            req_valid,
    output logic [VA_W-1:0] req_vaddr,
    output tlb_src_e        req_src,
    output logic            i_stall
);
    // Fixed-priority grant: data first, then instruction.
    always_comb begin
        req_valid = i_valid | d_valid;
        i_stall   = i_valid & d_valid;
        if (d_valid) begin
            req_vaddr = d_vaddr;
            req_src   = SRC_DATA;
        end else begin
            req_vaddr = i_vaddr;
            req_src   = SRC_INST;
        end
    end
endmodule

// File: rtl/tlb_cam.sv
// Module: tlb_cam
// Fully associative store of page mappings with parallel compare.
// Assumes ENTRIES is a power of two. Valid flags reset and flush to zero;
// page numbers carry no reset because the valid flag gates them.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = TLB_ENTRIES,
    parameter int VPN_W   = TLB_VA_W - TLB_OFF_W,
    parameter int PPN_W   = TLB_PPN_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);

        // Valid flag: cleared by reset or flush, else set by a write.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == SLOT) begin
                valid_q[g] <= wr_valid;
            end
        end

        // Mapping payload: loaded on a write to this slot.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == SLOT) begin
                vpn_q[g] <= wr_vpn;
                ppn_q[g] <= wr_ppn;
            end
        end

        // Per-slot compare, gated by the valid flag.
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    end

    // Select the lowest-numbered matching slot.
    always_comb begin
        hit     = |match;
        hit_ppn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_ppn = ppn_q[i];
        end
    end
endmodule

// File: rtl/tlb_miss_capture.sv
// Module: tlb_miss_capture
// Holds the page number of the first unserved miss and the trap line.
// Assumes software clears the trap by refilling or acknowledging.
// A clear in the same cycle as a new miss drops the trap; the miss is
// seen again when the request is retried.
module tlb_miss_capture #(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss,
    input  logic [VPN_W-1:0] miss_vpn_in,
    input  logic             clear,
    output logic             trap_req,
    output logic [VPN_W-1:0] miss_vpn
);
    // Capture on the first miss, hold while pending, drop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req <= 1'b0;
            miss_vpn <= '0;
        end else if (trap_req) begin
            if (clear) trap_req <= 1'b0;
        end else if (miss) begin
            trap_req <= 1'b1;
            miss_vpn <= miss_vpn_in;
        end
    end
endmodule

// File: rtl/sw_tlb.sv
// Module: sw_tlb
// Shared instruction/data translation buffer, refilled by software.
// Combinational lookup; miss raises a trap holding the faulting page.
// Assumes 4 KB pages and a power-of-two slot count.
module sw_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W     = TLB_VA_W,
    parameter int OFF_W    = TLB_OFF_W,
    parameter int PPN_W    = TLB_PPN_W,
    parameter int ENTRIES  = TLB_ENTRIES,
    localparam int VPN_W   = VA_W - OFF_W,
    localparam int PA_W    = PPN_W + OFF_W,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ireq_valid,
    input  logic [VA_W-1:0]  ireq_vaddr,
    input  logic             dreq_valid,
    input  logic [VA_W-1:0]  dreq_vaddr,
    output logic             istall,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_is_data,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             trap_req,
    output logic [VPN_W-1:0] miss_vpn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_valid,
    input  logic             trap_ack,
    input  logic             flush_all
);
    logic            req_valid;
    logic [VA_W-1:0] req_vaddr;
    tlb_src_e        req_src;
    logic            cam_hit;
    logic [PPN_W-1:0] cam_ppn;

    tlb_arbiter #(.VA_W(VA_W)) u_arb (
        .i_valid   (ireq_valid),
        .i_vaddr   (ireq_vaddr),
        .d_valid   (dreq_valid),
        .d_vaddr   (dreq_vaddr),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .req_src   (req_src),
        .i_stall   (istall)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_all),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (wr_vpn),
        .wr_ppn   (wr_ppn),
        .wr_valid (wr_valid),
        .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .hit      (cam_hit),
        .hit_ppn  (cam_ppn)
    );

    // Qualify compare results with the presence of a request.
    always_comb begin
        lk_hit     = req_valid & cam_hit;
        lk_miss    = req_valid & ~cam_hit;
        lk_is_data = req_valid & (req_src == SRC_DATA);
        lk_paddr   = {cam_ppn, req_vaddr[OFF_W-1:0]};
    end

    tlb_miss_capture #(.VPN_W(VPN_W)) u_miss (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss        (lk_miss),
        .miss_vpn_in (req_vaddr[VA_W-1:OFF_W]),
        .clear       (wr_en | trap_ack),
        .trap_req    (trap_req),
        .miss_vpn    (miss_vpn)
    );
endmodule

// Module: sw_tlb_checker
// Port-level temporal checks on sw_tlb, attached with bind.
module sw_tlb_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32,
    localparam int VPN_W = VA_W - OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ireq_valid,
    input logic [VA_W-1:0]  ireq_vaddr,
    input logic             dreq_valid,
    input logic [VA_W-1:0]  dreq_vaddr,
    input logic             istall,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_is_data,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             trap_req,
    input logic [VPN_W-1:0] miss_vpn,
    input logic             wr_en,
    input logic             trap_ack,
    input logic             flush_all
);
    logic [VA_W-1:0] sel_vaddr;
    assign sel_vaddr = dreq_valid ? dreq_vaddr : ireq_vaddr;

    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ireq_valid || dreq_valid) |-> (lk_hit ^ lk_miss));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ireq_valid || dreq_valid) |-> (!lk_hit && !lk_miss));
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == sel_vaddr[OFF_W-1:0]));
    p_data_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && ireq_valid) |-> (istall && lk_is_data));
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss && !trap_req) |=> (trap_req && miss_vpn == $past(sel_vaddr[VA_W-1:OFF_W])));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !wr_en && !trap_ack) |=> (trap_req && $stable(miss_vpn)));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && (wr_en || trap_ack)) |=> !trap_req);
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit);
endmodule

bind sw_tlb sw_tlb_checker #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ireq_valid (ireq_valid),
    .ireq_vaddr (ireq_vaddr),
    .dreq_valid (dreq_valid),
    .dreq_vaddr (dreq_vaddr),
    .istall     (istall),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_is_data (lk_is_data),
    .lk_paddr   (lk_paddr),
    .trap_req   (trap_req),
    .miss_vpn   (miss_vpn),
    .wr_en      (wr_en),
    .trap_ack   (trap_ack),
    .flush_all  (flush_all)
);

// File: tb/sw_tlb_bench.sv
// Directed bench for sw_tlb: one task per scenario, each self-checking.
module sw_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ireq_valid = 1'b0, dreq_valid = 1'b0;
    logic [31:0] ireq_vaddr = '0, dreq_vaddr = '0;
    logic        istall, lk_hit, lk_miss, lk_is_data, trap_req;
    logic [31:0] lk_paddr;
    logic [19:0] miss_vpn;
    logic        wr_en = 1'b0, wr_valid = 1'b0, trap_ack = 1'b0, flush_all = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sw_tlb u_sw_tlb (
        .clk(clk), .rst_n(rst_n),
        .ireq_valid(ireq_valid), .ireq_vaddr(ireq_vaddr),
        .dreq_valid(dreq_valid), .dreq_vaddr(dreq_vaddr),
        .istall(istall), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_is_data(lk_is_data), .lk_paddr(lk_paddr),
        .trap_req(trap_req), .miss_vpn(miss_vpn),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_valid(wr_valid), .trap_ack(trap_ack), .flush_all(flush_all)
    );

    function automatic logic [19:0] vpn_of(int i);
        return 20'hA0000 + 20'(i) * 20'h111;
    endfunction
    function automatic logic [19:0] ppn_of(int i);
        return 20'h50000 + 20'(i) * 20'd7;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_slot(input int idx, input logic [19:0] v, input logic [19:0] p, input bit val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = v; wr_ppn = p; wr_valid = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack_trap();
        @(negedge clk);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
    endtask

    // Data lookup held one cycle; checks result 1 ns after drive.
    task automatic data_lookup(input logic [31:0] va, input bit exp_hit, input logic [31:0] exp_pa, input string req);
        @(negedge clk);
        dreq_valid = 1'b1; dreq_vaddr = va;
        #1;
        check(lk_hit == exp_hit && lk_miss == !exp_hit, req, {30'd0, lk_hit, lk_miss}, {30'd0, exp_hit, !exp_hit});
        if (exp_hit) check(lk_paddr == exp_pa, req, lk_paddr, exp_pa);
        @(negedge clk);
        dreq_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(trap_req == 1'b0, "R9 reset trap", 32'(trap_req), 0);
        check(miss_vpn == 20'd0, "R9 reset miss_vpn", 32'(miss_vpn), 0);
        data_lookup(32'h1234_5678, 1'b0, 0, "R9 empty after reset");
        check(trap_req == 1'b1, "R4 trap raised", 32'(trap_req), 1);
        check(miss_vpn == 20'h12345, "R4 captured vpn", 32'(miss_vpn), 32'h12345);
        ack_trap();
        check(trap_req == 1'b0, "R6 ack clears", 32'(trap_req), 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) write_slot(i, vpn_of(i), ppn_of(i), 1'b1);
        for (int i = 0; i < 16; i++)
            data_lookup({vpn_of(i), 12'h0F0 + 12'(i)}, 1'b1, {ppn_of(i), 12'h0F0 + 12'(i)}, "R2 R1 R8 slot hit");
        check(trap_req == 1'b0, "R11 no trap on hits", 32'(trap_req), 0);
    endtask

    task automatic t_invalid_and_hold();
        write_slot(5, vpn_of(5), ppn_of(5), 1'b0);
        data_lookup({vpn_of(5), 12'h123}, 1'b0, 0, "R3 invalid slot misses");
        check(trap_req && miss_vpn == vpn_of(5), "R4 capture", 32'(miss_vpn), 32'(vpn_of(5)));
        data_lookup(32'h7777_7000, 1'b0, 0, "R5 second miss");
        check(trap_req && miss_vpn == vpn_of(5), "R5 vpn held", 32'(miss_vpn), 32'(vpn_of(5)));
        write_slot(5, vpn_of(5), ppn_of(5), 1'b1);
        check(trap_req == 1'b0, "R6 write clears", 32'(trap_req), 0);
        data_lookup({vpn_of(5), 12'hABC}, 1'b1, {ppn_of(5), 12'hABC}, "R8 refilled slot");
    endtask

    task automatic t_arb();
        @(negedge clk);
        ireq_valid = 1'b1; ireq_vaddr = {vpn_of(0), 12'h111};
        dreq_valid = 1'b1; dreq_vaddr = {vpn_of(1), 12'h222};
        #1;
        check(istall && lk_is_data, "R7 data wins", {30'd0, istall, lk_is_data}, 32'h3);
        check(lk_paddr == {ppn_of(1), 12'h222}, "R7 data paddr", lk_paddr, {ppn_of(1), 12'h222});
        dreq_valid = 1'b0;
        #1;
        check(!istall && !lk_is_data && lk_hit, "R7 inst alone", {29'd0, istall, lk_is_data, lk_hit}, 32'h1);
        check(lk_paddr == {ppn_of(0), 12'h111}, "R11 same-cycle paddr", lk_paddr, {ppn_of(0), 12'h111});
        @(negedge clk);
        ireq_valid = 1'b0;
        #1;
        check(!lk_hit && !lk_miss, "R11 idle quiet", {30'd0, lk_hit, lk_miss}, 0);
    endtask

    task automatic t_dup();
        write_slot(9, vpn_of(3), 20'hBEEF0, 1'b1);
        data_lookup({vpn_of(3), 12'h044}, 1'b1, {ppn_of(3), 12'h044}, "R10 lower slot wins");
        write_slot(3, vpn_of(3), ppn_of(3), 1'b0);
        data_lookup({vpn_of(3), 12'h044}, 1'b1, {20'hBEEF0, 12'h044}, "R10 upper slot after drop");
    endtask

    task automatic t_flush();
        @(negedge clk);
        flush_all = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd2; wr_vpn = 20'h33333; wr_ppn = 20'h44444; wr_valid = 1'b1;
        @(negedge clk);
        flush_all = 1'b0; wr_en = 1'b0;
        data_lookup({vpn_of(0), 12'h0}, 1'b0, 0, "R9 flush clears");
        ack_trap();
        data_lookup(32'h3333_3000, 1'b0, 0, "R9 flush beats write");
        ack_trap();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_invalid_and_hold();
        t_arb();
        t_dup();
        t_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule